// File: doc/BRIEF.md
# SPI Master Serializer with Automatic Fill

This block is the shift engine of an SPI master. Bytes written into a four-entry transmit queue are shifted out most significant bit first on `mosi`, with `sck` idling low and data sampled on its rising edge (mode 0). Each outgoing byte clocks one byte in from `miso`, and that byte is pushed into a four-entry receive queue. The serial clock is derived from the system clock by a programmable half-period count.

A long read needs a long run of outgoing bytes, because a byte is received only when one is sent. Software can avoid writing dummy bytes by enabling automatic fill. While fill is enabled and the transmit queue is empty, the engine starts filler bytes back to back. The filler is either the last byte taken from the queue or the fixed busy token 0xFF. Every filler byte raises a transmit underrun pulse. The fill controls can change only while the engine is fully idle. Status outputs report idle, transmit space and received data.

Top module: `spi_fill_master`

## Requirements
- R1: After reset, `sck` and `mosi` are low, `tx_idle` and `tx_free` are 1, `rx_valid` is 0, and no flag pulses.
- R2: Bits go out MSB first in mode 0. `sck` idles low, `mosi` is stable while `sck` is high, and `miso` is sampled on each rising `sck`.
- R3: Each byte sent pushes the eight bits sampled from `miso` into the receive queue. `rx_byte` shows the oldest entry, and `rx_rd` removes it.
- R4: `sck` stays high for `div_half` system clocks and low for `div_half` system clocks. A value of 0 acts as 1.
- R5: The transmit queue holds 4 bytes. `tx_free` is 0 while it is full, and a write while it is full is discarded.
- R6: `tx_idle` is 1 only when the transmit queue is empty and no byte is being shifted.
- R7: When a byte completes while the receive queue holds 4 bytes, that byte is dropped, `rx_overrun` pulses for one cycle, and the held bytes are unchanged.
- R8: When fill is enabled with `cfg_busy_tok`=0, the filler repeats the last byte taken from the transmit queue. Before any such byte exists, the filler is 0x00.
- R9: When fill is enabled with `cfg_busy_tok`=1, every filler byte is 0xFF.
- R10: `tx_underrun` pulses for one cycle at the start of every filler byte, and never for a byte taken from the queue.
- R11: A `cfg_wr` is accepted only in a cycle where `tx_idle` is 1, and it governs the start decision of that same cycle. In any other cycle it is ignored.
- R12: After fill is disabled, no further `sck` edges occur and the bytes already in the receive queue are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_half | input | DIVW | SCK half period in system clocks |
| tx_wr | input | 1 | Push `tx_byte` into the transmit queue |
| tx_byte | input | 8 | Byte to transmit |
| tx_free | output | 1 | Transmit queue has space |
| tx_idle | output | 1 | Transmit queue empty and engine idle |
| rx_rd | input | 1 | Pop the oldest received byte |
| rx_byte | output | 8 | Oldest received byte |
| rx_valid | output | 1 | Receive queue not empty |
| cfg_wr | input | 1 | Write the fill settings |
| cfg_auto | input | 1 | Fill enable value |
| cfg_busy_tok | input | 1 | Filler select: 0 repeat last byte, 1 send 0xFF |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| tx_underrun | output | 1 | One-cycle pulse per filler byte |
| rx_overrun | output | 1 | One-cycle pulse per dropped received byte |

## Verification
A stale last-byte register or a wrong filler select shows up on `mosi` during the first filler byte after fill is enabled, within 16 half periods. A queue count that is off by one shows up as a missing or extra byte at the bus-side slave model, a missing overrun pulse, or a `tx_free` level that is wrong right after a burst of writes. A fill setting that leaks through while busy, or a disable that is not honoured, shows up as `sck` edges that continue after the engine should have gone quiet, seen within one byte time.

// File: rtl/spi_fill_master.sv
`timescale 1ns/1ps
module spi_fill_master #(
  parameter int DEPTH = 4,
  parameter int DIVW  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DIVW-1:0] div_half,
  input  logic            tx_wr,
  input  logic [7:0]      tx_byte,
  output logic            tx_free,
  output logic            tx_idle,
  input  logic            rx_rd,
  output logic [7:0]      rx_byte,
  output logic            rx_valid,
  input  logic            cfg_wr,
  input  logic            cfg_auto,
  input  logic            cfg_busy_tok,
  output logic            sck,
  output logic            mosi,
  input  logic            miso,
  output logic            tx_underrun,
  output logic            rx_overrun
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0]   FULL = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  logic [7:0]      txq [DEPTH];
  logic [7:0]      rxq [DEPTH];
  logic [AW-1:0]   tx_wp, tx_rp, rx_wp, rx_rp;
  logic [AW:0]     tx_cnt, rx_cnt;
  logic            busy, sck_r, auto_en, fill_tok;
  logic [2:0]      bit_n;
  logic [DIVW-1:0] half_n, hterm;
  logic [7:0]      sh_tx, sh_rx, last_b;

  wire tx_empty   = (tx_cnt == '0);
  wire idle_now   = !busy && tx_empty;
  wire cfg_ok     = cfg_wr && idle_now;
  wire auto_go    = cfg_ok ? cfg_auto : auto_en;
  wire tok_go     = cfg_ok ? cfg_busy_tok : fill_tok;
  wire start_q    = !busy && !tx_empty;
  wire start_fill = idle_now && auto_go;
  wire push_tx    = tx_wr && (tx_cnt != FULL);
  assign hterm    = (div_half == '0) ? '0 : div_half - 1'b1;
  wire edge_t     = busy && (half_n == hterm);
  wire fall_last  = edge_t && sck_r && (bit_n == 3'd7);
  wire rx_full    = (rx_cnt == FULL);
  wire rx_push    = fall_last && !rx_full;
  wire rx_pop     = rx_rd && (rx_cnt != '0);

  assign tx_free  = (tx_cnt != FULL);
  assign tx_idle  = idle_now;
  assign rx_valid = (rx_cnt != '0);
  assign rx_byte  = rxq[rx_rp];
  assign sck      = sck_r;
  assign mosi     = sh_tx[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
      busy <= 1'b0; sck_r <= 1'b0; bit_n <= '0; half_n <= '0;
      sh_tx <= '0; sh_rx <= '0; last_b <= 8'h00;
      auto_en <= 1'b0; fill_tok <= 1'b0;
      tx_underrun <= 1'b0; rx_overrun <= 1'b0;
    end else begin
      tx_underrun <= 1'b0;
      rx_overrun  <= fall_last && rx_full;
      if (cfg_ok) begin
        auto_en  <= cfg_auto;
        fill_tok <= cfg_busy_tok;
      end
      if (push_tx) begin
        txq[tx_wp] <= tx_byte;
        tx_wp <= nxt(tx_wp);
      end
      tx_cnt <= tx_cnt + (push_tx ? 1'b1 : 1'b0) - (start_q ? 1'b1 : 1'b0);
      if (start_q) begin
        sh_tx  <= txq[tx_rp];
        last_b <= txq[tx_rp];
        tx_rp  <= nxt(tx_rp);
      end else if (start_fill) begin
        sh_tx       <= tok_go ? 8'hFF : last_b;
        tx_underrun <= 1'b1;
      end
      if (start_q || start_fill) begin
        busy <= 1'b1; bit_n <= '0; half_n <= '0;
      end else if (busy) begin
        if (edge_t) begin
          half_n <= '0;
          if (!sck_r) begin
            sck_r <= 1'b1;
            sh_rx <= {sh_rx[6:0], miso};
          end else begin
            sck_r <= 1'b0;
            if (bit_n == 3'd7) busy <= 1'b0;
            else begin
              bit_n <= bit_n + 1'b1;
              sh_tx <= {sh_tx[6:0], 1'b0};
            end
          end
        end else half_n <= half_n + 1'b1;
      end
      if (rx_push) begin
        rxq[rx_wp] <= sh_rx;
        rx_wp <= nxt(rx_wp);
      end
      rx_cnt <= rx_cnt + (rx_push ? 1'b1 : 1'b0) - (rx_pop ? 1'b1 : 1'b0);
      if (rx_pop) rx_rp <= nxt(rx_rp);
    end
  end

  // R2
  sck_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(sck) |-> busy);
  // R2
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (sck && $past(sck)) |-> $stable(mosi));
  // R4
  half_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |-> half_n <= hterm);
  // R5
  tx_full_chk: assert property (@(posedge clk) disable iff (!rst_n) (tx_wr && !tx_free && busy) |=> !tx_free);
  // R6
  idle_sck_chk: assert property (@(posedge clk) disable iff (!rst_n) sck |-> !tx_idle);
  // R7
  overrun_full_chk: assert property (@(posedge clk) disable iff (!rst_n) rx_overrun |-> (rx_cnt == FULL || $past(rx_rd)));
  // R10
  underrun_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) tx_underrun |-> (busy && !sck));
  // R11
  cfg_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n) (cfg_wr && !tx_idle) |=> $stable(auto_en) && $stable(fill_tok));
endmodule

// File: tb/spi_fill_master_tb.sv
`timescale 1ns/1ps
module spi_fill_master_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] div_half = 8'd2;
  logic tx_wr = 0, rx_rd = 0, cfg_wr = 0, cfg_auto = 0, cfg_busy_tok = 0;
  logic [7:0] tx_byte = '0;
  logic tx_free, tx_idle, rx_valid, sck, mosi, miso, tx_underrun, rx_overrun;
  logic [7:0] rx_byte;

  always #5 clk = ~clk;

  spi_fill_master u_dut (
    .clk(clk), .rst_n(rst_n), .div_half(div_half), .tx_wr(tx_wr), .tx_byte(tx_byte),
    .tx_free(tx_free), .tx_idle(tx_idle), .rx_rd(rx_rd), .rx_byte(rx_byte),
    .rx_valid(rx_valid), .cfg_wr(cfg_wr), .cfg_auto(cfg_auto), .cfg_busy_tok(cfg_busy_tok),
    .sck(sck), .mosi(mosi), .miso(miso), .tx_underrun(tx_underrun), .rx_overrun(rx_overrun));

  // Slave model: shifts slv_byte out MSB first, captures mosi on rising sck.
  logic [7:0] slv_byte = 8'h00;
  logic [2:0] bitidx = 3'd0;
  logic [7:0] slv_rx = 8'h00;
  logic [7:0] got [64];
  int nrise = 0, nbytes = 0, nund = 0, novr = 0;
  time t_prev = 0, t_cur = 0;
  assign miso = slv_byte[3'd7 - bitidx];
  always @(negedge sck) bitidx <= bitidx + 3'd1;
  always @(posedge sck) begin
    slv_rx = {slv_rx[6:0], mosi};
    if (nrise % 8 == 7) begin got[nbytes % 64] = slv_rx; nbytes = nbytes + 1; end
    nrise = nrise + 1;
    t_prev = t_cur; t_cur = $time;
  end
  always @(posedge clk) begin
    if (tx_underrun) nund = nund + 1;
    if (rx_overrun) novr = novr + 1;
  end

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    tx_byte = b; tx_wr = 1; @(negedge clk); tx_wr = 0;
  endtask
  task automatic wait_idle();
    while (tx_idle) @(negedge clk);
    while (!tx_idle) @(negedge clk);
  endtask
  task automatic pop();
    rx_rd = 1; @(negedge clk); rx_rd = 0;
  endtask
  task automatic drain();
    while (rx_valid) pop();
  endtask
  task automatic set_cfg(input logic a, input logic t);
    while (!tx_idle) @(negedge clk);
    cfg_auto = a; cfg_busy_tok = t; cfg_wr = 1; @(negedge clk); cfg_wr = 0;
  endtask

  localparam logic [15:0] VEC [5] = '{16'hA5_3C, 16'h01_80, 16'h7E_E7, 16'hFF_00, 16'h00_FF};

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int b0, u0, r0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sck == 0 && mosi == 0, "R1 sck/mosi", {sck, mosi}, 0);
    chk(tx_idle && tx_free && !rx_valid, "R1 status", {tx_idle, tx_free, rx_valid}, 3'b110);
    rst_n = 1; @(negedge clk);

    // R2 R3 vector table
    foreach (VEC[i]) begin
      b0 = nbytes;
      slv_byte = VEC[i][7:0];
      wr(VEC[i][15:8]);
      repeat (3) @(negedge clk);
      chk(!tx_idle, "R6 idle low while shifting", tx_idle, 0);
      wait_idle();
      chk(got[b0 % 64] == VEC[i][15:8], "R2 mosi byte", got[b0 % 64], VEC[i][15:8]);
      chk(rx_valid && rx_byte == VEC[i][7:0], "R3 rx byte", rx_byte, VEC[i][7:0]);
      pop();
      chk(!rx_valid, "R3 rx empty after read", rx_valid, 0);
    end

    // R4 divider
    div_half = 8'd3; wr(8'h55); wait_idle();
    chk(t_cur - t_prev == 60, "R4 period div3", int'(t_cur - t_prev), 60);
    div_half = 8'd0; wr(8'h55); wait_idle();
    chk(t_cur - t_prev == 20, "R4 period div0", int'(t_cur - t_prev), 20);
    drain(); div_half = 8'd2;

    // R5 R7 burst of five plus a write while full
    b0 = nbytes; r0 = novr; slv_byte = 8'hC3;
    for (int i = 0; i < 5; i++) begin tx_byte = 8'h10 + 8'(i); tx_wr = 1; @(negedge clk); end
    tx_wr = 0;
    chk(!tx_free, "R5 tx_free low when full", tx_free, 0);
    wr(8'hEE);
    wait_idle();
    repeat (40) @(negedge clk);
    chk(nbytes - b0 == 5, "R5 full write dropped", nbytes - b0, 5);
    chk(got[(b0 + 4) % 64] == 8'h14, "R5 order", got[(b0 + 4) % 64], 8'h14);
    chk(novr - r0 == 1, "R7 overrun pulse", novr - r0, 1);
    chk(rx_byte == 8'hC3, "R7 held data", rx_byte, 8'hC3);
    r0 = 0;
    while (rx_valid) begin pop(); r0++; end
    chk(r0 == 4, "R7 four held", r0, 4);

    // R8 R10 R12 repeat-last fill
    slv_byte = 8'h5A; b0 = nbytes; u0 = nund;
    set_cfg(1, 0);
    while (nbytes < b0 + 3) @(negedge clk);
    set_cfg(0, 0);
    chk(got[b0 % 64] == 8'h14 && got[(b0 + 2) % 64] == 8'h14, "R8 repeat last", got[b0 % 64], 8'h14);
    r0 = nrise;
    repeat (100) @(negedge clk);
    chk(nrise == r0, "R12 no sck after disable", nrise, r0);
    chk(nund - u0 == nbytes - b0, "R10 underrun per filler", nund - u0, nbytes - b0);
    chk(rx_valid && rx_byte == 8'h5A, "R12 rx kept", rx_byte, 8'h5A);
    drain();

    // R9 R10 busy token
    b0 = nbytes; u0 = nund;
    set_cfg(1, 1);
    while (nbytes < b0 + 2) @(negedge clk);
    set_cfg(0, 0);
    repeat (60) @(negedge clk);
    chk(got[b0 % 64] == 8'hFF && got[(b0 + 1) % 64] == 8'hFF, "R9 busy token", got[b0 % 64], 8'hFF);
    chk(nund - u0 == nbytes - b0, "R10 underrun count token", nund - u0, nbytes - b0);
    drain();

    // R11 config write while busy ignored
    b0 = nbytes; u0 = nund;
    tx_byte = 8'h11; tx_wr = 1; @(negedge clk); tx_wr = 0;
    repeat (3) @(negedge clk);
    cfg_auto = 1; cfg_busy_tok = 1; cfg_wr = 1; @(negedge clk); cfg_wr = 0;
    wait_idle();
    repeat (60) @(negedge clk);
    chk(nbytes - b0 == 1, "R11 busy cfg ignored", nbytes - b0, 1);
    chk(nund == u0 && tx_idle, "R11 no filler", nund - u0, 0);
    drain();

    // R8 reset value of last byte
    rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    b0 = nbytes; slv_byte = 8'h00;
    set_cfg(1, 0);
    while (nbytes < b0 + 1) @(negedge clk);
    set_cfg(0, 0);
    chk(got[b0 % 64] == 8'h00, "R8 reset last 00", got[b0 % 64], 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule